// File: doc/BRIEF.md
# Digit-Serial Word Adder

This block adds two unsigned operands of `WORD_W` bits that are streamed in least significant digit first, `DIGIT_W` bits per clock, so one word takes `WORD_W/DIGIT_W` clocks. The caller raises `word_first` with the lowest digit of every word. Each clock yields one sum digit. The word sum is modulo 2^`WORD_W`, and no overflow indication is produced.

Inside, `DIGIT_W` full-adder cells form a combinational carry ripple. A single carry flop closes the loop from the top cell back to the bottom cell. The carry that enters the bottom cell is forced to zero whenever `word_first` is high, so no carry crosses from one word into the next. Two settings give the limiting cases: `DIGIT_W = 1` makes a bit-serial adder, and `DIGIT_W = WORD_W` makes a bit-parallel adder in which every digit is a whole word. The `REG_OUT` parameter chooses a combinational sum digit (0) or a registered sum digit with one clock of latency (1).

Top module: `serial_digit_adder`

## Requirements
- R1: `WORD_W` must be a whole multiple of `DIGIT_W`, and `REG_OUT` must be 0 or 1. Any other setting stops elaboration.
- R2: On a digit with `word_first` = 1, the sum digit equals (`a_dig` + `b_dig`) mod 2^`DIGIT_W`. The carry-in is zero.
- R3: On a digit with `word_first` = 0, the sum digit equals (`a_dig` + `b_dig` + c) mod 2^`DIGIT_W`. Here c is the carry out of the top bit of the previous clock's digit addition.
- R4: For the widths W = 8 and J in {1, 2, 4}, the digits of one framed word, placed at bit offset J·k for the k-th digit, reassemble to (A + B) mod 2^W.
- R5: A carry out of the last digit of a word has no effect on the first digit of the next word.
- R6: Reset clears the carry flop. The first digit after reset receives a zero carry even when `word_first` is low.
- R7: With `REG_OUT` = 1, each sum digit appears one clock after its operand digits, and `sum_dig` is 0 while reset is held.
- R8: With `DIGIT_W` = `WORD_W`, every word is a single digit flagged by `word_first`, and `sum_dig` is (A + B) mod 2^W in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_first | input | 1 | High on the least significant digit of each word |
| a_dig | input | DIGIT_W | Operand A digit |
| b_dig | input | DIGIT_W | Operand B digit |
| sum_dig | output | DIGIT_W | Sum digit; registered when REG_OUT = 1 |

## Verification
Word framing and carry propagation meet when a word ends with a carry out and the next word starts in the very next clock. In that cycle the pending carry must be discarded at the same moment new operands enter. The bench provokes this with back-to-back words such as all-ones plus one, followed at once by a zero word and then by all-ones plus all-ones. A cycle-by-cycle reference that tracks its own carry predicts each digit. That prediction is compared against the port, and each reassembled word is also compared with modular addition.

// File: rtl/sda_pkg.sv
package sda_pkg;
   // number of digit slots that make up one word
   function automatic int digits_per_word(input int word_w, input int digit_w);
      return word_w / digit_w;
   endfunction

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/sda_fa_cell.sv
module sda_fa_cell (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   always_comb begin
      s_o = x_i ^ y_i ^ c_i;
      c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
   end
endmodule

// File: rtl/sda_digit_ripple.sv
module sda_digit_ripple #(
   parameter int DIGIT_W = 2
) (
   input  logic [DIGIT_W-1:0] a_i,
   input  logic [DIGIT_W-1:0] b_i,
   input  logic               cin_i,
   output logic [DIGIT_W-1:0] sum_o,
   output logic               cout_o
);
   logic [DIGIT_W:0] chain;

   assign chain[0] = cin_i;

   // carry edges between cells carry no delay
   for (genvar g = 0; g < DIGIT_W; g++) begin : g_cell
      sda_fa_cell u_fa (
         .x_i (a_i[g]),
         .y_i (b_i[g]),
         .c_i (chain[g]),
         .s_o (sum_o[g]),
         .c_o (chain[g+1])
      );
   end

   assign cout_o = chain[DIGIT_W];
endmodule

// File: rtl/sda_carry_stage.sv
module sda_carry_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic word_first,
   input  logic cout_i,
   output logic cin_o
);
   logic carry_q;

   // the single delayed edge of the carry loop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= 1'b0;
      else        carry_q <= cout_i;
   end

   // word-boundary switch: bottom cell sees zero on a word's first digit
   assign cin_o = word_first ? 1'b0 : carry_q;
endmodule

// File: rtl/sda_out_reg.sv
module sda_out_reg #(
   parameter int DIGIT_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIGIT_W-1:0] d_i,
   output logic [DIGIT_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end
endmodule

// File: rtl/serial_digit_adder.sv
module serial_digit_adder #(
   parameter int WORD_W  = 8,
   parameter int DIGIT_W = 2,
   parameter int REG_OUT = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_first,
   input  logic [DIGIT_W-1:0] a_dig,
   input  logic [DIGIT_W-1:0] b_dig,
   output logic [DIGIT_W-1:0] sum_dig
);
   import sda_pkg::*;

   localparam int        NUM_DIGITS = digits_per_word(WORD_W, DIGIT_W);
   localparam out_mode_e OUT_MODE   = (REG_OUT != 0) ? OUT_REG : OUT_COMB;

   // R1: parameter legality
   if (DIGIT_W < 1 || DIGIT_W > WORD_W) begin : g_bad_digit
      $error("serial_digit_adder: DIGIT_W out of range");
   end
   if (NUM_DIGITS * DIGIT_W != WORD_W) begin : g_bad_ratio
      $error("serial_digit_adder: WORD_W is not a multiple of DIGIT_W");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_mode
      $error("serial_digit_adder: REG_OUT must be 0 or 1");
   end

   logic               cin;
   logic               cout;
   logic [DIGIT_W-1:0] raw_sum;

   sda_carry_stage u_carry (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_first (word_first),
      .cout_i     (cout),
      .cin_o      (cin)
   );

   sda_digit_ripple #(.DIGIT_W(DIGIT_W)) u_ripple (
      .a_i    (a_dig),
      .b_i    (b_dig),
      .cin_i  (cin),
      .sum_o  (raw_sum),
      .cout_o (cout)
   );

   if (OUT_MODE == OUT_REG) begin : g_out_reg
      sda_out_reg #(.DIGIT_W(DIGIT_W)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw_sum),
         .q_o   (sum_dig)
      );
   end else begin : g_out_comb
      assign sum_dig = raw_sum;
   end
endmodule

// File: rtl/sda_checker.sv
module sda_checker #(
   parameter int DIGIT_W = 2,
   parameter int REG_OUT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               word_first,
   input logic [DIGIT_W-1:0] a_dig,
   input logic [DIGIT_W-1:0] b_dig,
   input logic [DIGIT_W-1:0] sum_dig
);
   // operands aligned to the cycle in which their sum is visible
   logic [DIGIT_W-1:0] a_v, b_v, a_p, b_p;
   logic               f_v, ok_v, ok_p;
   logic [DIGIT_W-1:0] base, base_inc;

   if (REG_OUT != 0) begin : g_align_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_v <= '0; b_v <= '0; f_v <= 1'b0; ok_v <= 1'b0;
         end else begin
            a_v <= a_dig; b_v <= b_dig; f_v <= word_first; ok_v <= 1'b1;
         end
      end
      // R7: registered output is cleared while reset is held
      assert_reset_out_R7: assert property (@(posedge clk) !rst_n |-> (sum_dig == '0));
   end else begin : g_align_comb
      always_comb begin
         a_v = a_dig; b_v = b_dig; f_v = word_first; ok_v = rst_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_p <= '0; b_p <= '0; ok_p <= 1'b0;
      end else begin
         a_p <= a_v; b_p <= b_v; ok_p <= ok_v;
      end
   end

   always_comb begin
      base     = DIGIT_W'(a_v + b_v);
      base_inc = base + 1'b1;
   end

   // R2: first digit of a word adds with zero carry-in
   assert_first_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_v && f_v) |-> (sum_dig == base));

   // R3: other digits add at most one carry
   assert_cin_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_v && !f_v) |-> (sum_dig == base || sum_dig == base_inc));

   // R3: both previous operands all ones always produce a carry
   assert_carry_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_v && ok_p && !f_v && (&a_p) && (&b_p)) |-> (sum_dig == base_inc));

   // R3 / R6: both previous operands zero never produce a carry
   assert_carry_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_v && ok_p && !f_v && a_p == '0 && b_p == '0) |-> (sum_dig == base));
endmodule

bind serial_digit_adder sda_checker #(
   .DIGIT_W (DIGIT_W),
   .REG_OUT (REG_OUT)
) u_sda_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_first (word_first),
   .a_dig      (a_dig),
   .b_dig      (b_dig),
   .sum_dig    (sum_dig)
);

// File: tb/test_serial_digit_adder.sv
module sda_lane #(
   parameter int W = 8,
   parameter int J = 2,
   parameter int R = 0
) (
   input  logic clk,
   output int   errs,
   output int   chks,
   output logic done
);
   localparam int N   = W / J;
   localparam int LAT = (R != 0) ? 1 : 0;

   logic         rst_n;
   logic         wf;
   logic [J-1:0] a, b;
   logic [J-1:0] s;

   serial_digit_adder #(.WORD_W(W), .DIGIT_W(J), .REG_OUT(R)) i_serial_digit_adder (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_first (wf),
      .a_dig      (a),
      .b_dig      (b),
      .sum_dig    (s)
   );

   int    q_exp[$];
   int    q_idx[$];
   longint q_wexp[$];
   string q_tag[$];
   int    mc;
   longint acc;

   task automatic check(input longint act, input longint exp, input string tag);
      chks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s lane W=%0d J=%0d R=%0d: actual=%0h expected=%0h",
                  tag, W, J, R, act, exp);
      end
   endtask

   // one clock: drive a digit, advance the reference, compare the due output
   task automatic cycle(input logic [J-1:0] av, input logic [J-1:0] bv, input logic f,
                        input int idx, input longint wexp, input string tag);
      int tot;
      @(negedge clk);
      a = av; b = bv; wf = f;
      tot = int'(av) + int'(bv) + (f ? 0 : mc);
      mc  = tot >> J;
      q_exp.push_back(tot % (1 << J));
      q_idx.push_back(idx);
      q_wexp.push_back(wexp);
      q_tag.push_back(tag);
      #5;
      if (q_exp.size() > LAT) begin
         int    e  = q_exp.pop_front();
         int    ix = q_idx.pop_front();
         longint we = q_wexp.pop_front();
         string tg = q_tag.pop_front();
         check(longint'(s), longint'(e), tg);
         if (ix == 0) acc = 0;
         if (ix >= 0) begin
            acc = acc | (longint'(s) << (ix * J));
            if (ix == N - 1) check(acc, we, (J == W) ? "R8" : "R4");
         end
      end
   endtask

   task automatic send_word(input logic [W-1:0] wa, input logic [W-1:0] wb, input string first_tag);
      logic [W-1:0] ws;
      ws = wa + wb;
      for (int k = 0; k < N; k++) begin
         cycle(J'(wa >> (k * J)), J'(wb >> (k * J)), (k == 0), k, longint'(ws),
               (k == 0) ? first_tag : "R3");
      end
   endtask

   initial begin
      errs = 0; chks = 0; done = 1'b0; mc = 0; acc = 0;
      rst_n = 1'b1; wf = 1'b0; a = '0; b = '0;
      #2 rst_n = 1'b0;
      // reset phase: carry held clear, registered output held at zero
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         a = '1; b = '1; wf = 1'b0;
         #5;
         if (R != 0) check(longint'(s), 0, "R7");
         else        check(longint'(s), longint'(J'(a + b)), "R6");
      end
      a = '0; b = '0;
      rst_n = 1'b1;
      mc = 0;
      // R6: unframed first digit after reset sees zero carry ('1 + 1 wraps to 0)
      cycle('1, J'(1), 1'b0, -1, 0, (R != 0) ? "R6/R7" : "R6");
      // R5: carry out of a word must not reach the next word
      send_word('1, W'(1), "R2");
      send_word('0, '0, "R5");
      send_word('1, '1, "R5");
      send_word({(W/2){2'b10}}, {(W/2){2'b01}}, "R5");
      send_word('1, '1, "R2");
      for (int n = 0; n < 40; n++) begin
         send_word(W'($urandom), W'($urandom), "R2");
      end
      cycle('0, '0, 1'b1, -1, 0, "drain");
      cycle('0, '0, 1'b1, -1, 0, "drain");
      done = 1'b1;
   end
endmodule

module test_serial_digit_adder;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   int   e1, e2, e4, e2r, e8;
   int   c1, c2, c4, c2r, c8;
   logic d1, d2, d4, d2r, d8;
   logic timed_out = 1'b0;

   // R4: J = 1, 2, 4 with W = 8; R7: registered variant; R8: bit-parallel
   sda_lane #(.W(8), .J(1), .R(0)) u_lane_j1  (.clk(clk), .errs(e1),  .chks(c1),  .done(d1));
   sda_lane #(.W(8), .J(2), .R(0)) u_lane_j2  (.clk(clk), .errs(e2),  .chks(c2),  .done(d2));
   sda_lane #(.W(8), .J(4), .R(0)) u_lane_j4  (.clk(clk), .errs(e4),  .chks(c4),  .done(d4));
   sda_lane #(.W(8), .J(2), .R(1)) u_lane_j2r (.clk(clk), .errs(e2r), .chks(c2r), .done(d2r));
   sda_lane #(.W(8), .J(8), .R(0)) u_lane_j8  (.clk(clk), .errs(e8),  .chks(c8),  .done(d8));

   initial begin
      int errors, total;
      fork
         wait (d1 && d2 && d4 && d2r && d8);
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      errors = e1 + e2 + e4 + e2r + e8;
      total  = c1 + c2 + c4 + c2r + c8;
      if (timed_out && !(d1 && d2 && d4 && d2r && d8)) begin
         errors++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
   end
endmodule